// File: doc/BRIEF.md
# Sector Error Fixup Engine

This block applies the result of a hardware ECC decode to one 512-byte sector held in a byte-wide RAM. On a start pulse it takes a status word and three location words. The status word carries the error count. Together the four words carry up to eight packed 13-bit error bit positions. For each reported position that falls inside the sector, the block flips the matching bit with a read-modify-write of one RAM byte. The syndrome computation that produces these words happens upstream and is not part of this block.

When the count says the sector cannot be corrected, the block tests whether the sector is an erased page. An erased page legitimately reads back as all ones, but its ECC bytes do not match the data. The test counts zero bits, first in the 13 ECC bytes supplied with the start pulse and then in the sector bytes, and stops as soon as more than eight zeros have been seen. If eight or fewer zeros are found, the page is treated as erased: any stray data zeros are overwritten with 0xFF, and their number is reported as the corrected count. Otherwise the block reports failure.

Top module: `sector_fix_engine`

## Requirements
- R1: An error count of 0 produces a done pulse in the cycle after start. The corrected count is 0, fail is 0, and the RAM is not accessed.
- R2: The error count is taken from `stat_i[13:10]`. The location vector is `{stat_i[23:16], loc_w2_i, loc_w1_i, loc_w0_i}`, and index k is held in vector bits 13k+12 down to 13k. All other status bits are ignored. Inputs are captured at start.
- R3: Each index is XORed with 3 to give a bit position p. Bit p%8 of byte p/8 is inverted by reading that byte and then writing it back at the same address in the next cycle. RAM read data arrives one cycle after the read strobe.
- R4: A position of 4096 or more is skipped without any RAM access. The corrected count equals the number of flips applied, and a repeated position is flipped and counted again.
- R5: A count from 1 to 8 processes exactly indices 0 to count-1 in order. Indices at or above the count are ignored.
- R6: A count above 8 starts an erased-page test. The test counts zero bits of `ecc_i` (104 bits), then of sector bytes 0 to 511, and stops as soon as the total exceeds 8.
- R7: If the erased-page total is at most 8, all 512 bytes become 0xFF, the corrected count equals the number of data zero bits, and fail is 0. If there are no data zeros, the sector is not written.
- R8: If the erased-page total exceeds 8, fail is 1, the corrected count is 0, and the sector is left unchanged.
- R9: Each accepted start yields exactly one single-cycle done pulse. The corrected count and fail are valid with done and hold until the next done.
- R10: A start pulse that arrives while an operation is running is ignored.
- R11: After reset, done, fail and the corrected count are 0, and no RAM strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, one cycle |
| loc_w0_i | input | 32 | Location vector bits 31:0 |
| loc_w1_i | input | 32 | Location vector bits 63:32 |
| loc_w2_i | input | 32 | Location vector bits 95:64 |
| stat_i | input | 32 | Status word: count in 13:10, vector top byte in 23:16 |
| ecc_i | input | 104 | The 13 stored ECC bytes, for the erased-page test |
| mem_addr_o | output | 9 | Sector RAM byte address |
| mem_rd_o | output | 1 | RAM read strobe |
| mem_wr_o | output | 1 | RAM write strobe |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the read |
| done_o | output | 1 | End-of-operation pulse |
| fixed_cnt_o | output | 4 | Corrected bit count |
| fail_o | output | 1 | Uncorrectable sector |

## Verification
The hardest case to reach is the erased-page boundary. The zeros found in the ECC input and in the sector must add up to exactly eight or exactly nine, with the data zeros spread over bytes the scan reaches at different times. The stimulus table presets the RAM to all ones and clears a chosen number of ECC bits and data bits at scattered byte addresses. This covers totals of 8 and 9, ECC-only overflow and data-only cases. The correction cases place error positions that straddle the 32-bit word joins, the last bit of the sector, the first position past it, and a repeated position.

// File: rtl/sfix_pkg.sv
package sfix_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FIX_CHK,
    S_FIX_WR,
    S_SCAN_RD,
    S_SCAN_ACC,
    S_FILL
  } sfix_st_e;
endpackage

// File: rtl/sfix_loc_sel.sv
module sfix_loc_sel #(
  parameter int IDX_W     = 13,
  parameter int N_IDX     = 8,
  parameter int SECT_BITS = 4096,
  localparam int KW       = $clog2(N_IDX)
) (
  input  logic [IDX_W*N_IDX-1:0] vec_i,
  input  logic [KW-1:0]          sel_i,
  output logic [IDX_W-1:0]       pos_o,
  output logic                   in_rng_o
);
  logic [IDX_W-1:0] idx [N_IDX];

  for (genvar g = 0; g < N_IDX; g++) begin : g_unpack
    assign idx[g] = vec_i[g*IDX_W +: IDX_W] ^ IDX_W'(3);
  end

  assign pos_o    = idx[sel_i];
  assign in_rng_o = 32'(pos_o) < SECT_BITS;
endmodule

// File: rtl/sfix_zcount.sv
module sfix_zcount #(
  parameter int W  = 8,
  localparam int ZW = $clog2(W+1)
) (
  input  logic [W-1:0]  d_i,
  output logic [ZW-1:0] z_o
);
  always_comb begin
    z_o = '0;
    for (int i = 0; i < W; i++) z_o = z_o + ZW'(!d_i[i]);
  end
endmodule

// File: rtl/sector_fix_engine.sv
module sector_fix_engine #(
  parameter int SECT_BYTES = 512,
  parameter int ECC_BYTES  = 13,
  parameter int IDX_W      = 13,
  parameter int N_IDX      = 8,
  parameter int MAX_FIX    = 8,
  localparam int AW        = $clog2(SECT_BYTES),
  localparam int ECC_W     = ECC_BYTES*8,
  localparam int VEC_W     = IDX_W*N_IDX,
  localparam int CW        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      loc_w0_i,
  input  logic [31:0]      loc_w1_i,
  input  logic [31:0]      loc_w2_i,
  input  logic [31:0]      stat_i,
  input  logic [ECC_W-1:0] ecc_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             done_o,
  output logic [CW-1:0]    fixed_cnt_o,
  output logic             fail_o
);
  import sfix_pkg::*;

  localparam int SECT_BITS = SECT_BYTES*8;
  localparam int KW        = $clog2(N_IDX);
  localparam int EZW       = $clog2(ECC_W+1);
  localparam int TW        = 8;
  localparam logic [CW-1:0] MAX_C = CW'(MAX_FIX);
  localparam logic [TW-1:0] MAX_T = TW'(MAX_FIX);
  localparam logic [AW-1:0] LAST  = AW'(SECT_BYTES-1);

  sfix_st_e        st_q;
  logic [CW-1:0]   cnt_q, k_q, nfix_q, dz_q;
  logic [VEC_W-1:0] vec_q;
  logic [TW-1:0]   tot_q;
  logic [AW-1:0]   addr_q;
  logic            busy;

  logic [VEC_W-1:0] vec_in;
  logic [CW-1:0]    cnt_in;
  logic [IDX_W-1:0] pos;
  logic             in_rng;
  logic [EZW-1:0]   ecc_z;
  logic [3:0]       byte_z;
  logic [TW-1:0]    tot_nxt;
  logic [CW:0]      dz_nxt;

  assign vec_in = VEC_W'({stat_i[23:16], loc_w2_i, loc_w1_i, loc_w0_i});
  assign cnt_in = stat_i[13:10];
  assign busy   = st_q != S_IDLE;

  sfix_loc_sel #(.IDX_W(IDX_W), .N_IDX(N_IDX), .SECT_BITS(SECT_BITS)) u_sel (
    .vec_i   (vec_q),
    .sel_i   (k_q[KW-1:0]),
    .pos_o   (pos),
    .in_rng_o(in_rng)
  );

  sfix_zcount #(.W(ECC_W)) u_ecc_z (.d_i(ecc_i), .z_o(ecc_z));
  sfix_zcount #(.W(8))     u_byte_z (.d_i(mem_rdata_i), .z_o(byte_z));

  assign tot_nxt = tot_q + TW'(byte_z);
  assign dz_nxt  = {1'b0, dz_q} + (CW+1)'(byte_z);

  // RAM port
  always_comb begin
    mem_rd_o    = (st_q == S_FIX_CHK && k_q != cnt_q && in_rng) || st_q == S_SCAN_RD;
    mem_wr_o    = st_q == S_FIX_WR || st_q == S_FILL;
    mem_addr_o  = (st_q == S_FIX_CHK || st_q == S_FIX_WR) ? pos[3 +: AW] : addr_q;
    mem_wdata_o = (st_q == S_FIX_WR) ? (mem_rdata_i ^ (8'h01 << pos[2:0])) : 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      k_q         <= '0;
      nfix_q      <= '0;
      dz_q        <= '0;
      vec_q       <= '0;
      tot_q       <= '0;
      addr_q      <= '0;
      done_o      <= 1'b0;
      fixed_cnt_o <= '0;
      fail_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          cnt_q  <= cnt_in;
          vec_q  <= vec_in;
          k_q    <= '0;
          nfix_q <= '0;
          dz_q   <= '0;
          addr_q <= '0;
          tot_q  <= TW'(ecc_z);
          if (cnt_in == '0) begin
            done_o <= 1'b1; fixed_cnt_o <= '0; fail_o <= 1'b0;
          end else if (cnt_in <= MAX_C) begin
            st_q <= S_FIX_CHK;
          end else if (TW'(ecc_z) > MAX_T) begin
            done_o <= 1'b1; fixed_cnt_o <= '0; fail_o <= 1'b1;
          end else begin
            st_q <= S_SCAN_RD;
          end
        end
        S_FIX_CHK: begin
          if (k_q == cnt_q) begin
            done_o <= 1'b1; fixed_cnt_o <= nfix_q; fail_o <= 1'b0;
            st_q   <= S_IDLE;
          end else if (in_rng) begin
            st_q <= S_FIX_WR;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        S_FIX_WR: begin
          nfix_q <= nfix_q + 1'b1;
          k_q    <= k_q + 1'b1;
          st_q   <= S_FIX_CHK;
        end
        S_SCAN_RD: st_q <= S_SCAN_ACC;
        S_SCAN_ACC: begin
          tot_q <= tot_nxt;
          dz_q  <= dz_nxt[CW-1:0];
          if (tot_nxt > MAX_T) begin
            done_o <= 1'b1; fixed_cnt_o <= '0; fail_o <= 1'b1;
            st_q   <= S_IDLE;
          end else if (addr_q == LAST) begin
            if (dz_nxt == '0) begin
              done_o <= 1'b1; fixed_cnt_o <= '0; fail_o <= 1'b0;
              st_q   <= S_IDLE;
            end else begin
              addr_q <= '0;
              st_q   <= S_FILL;
            end
          end else begin
            addr_q <= addr_q + 1'b1;
            st_q   <= S_SCAN_RD;
          end
        end
        S_FILL: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST) begin
            done_o <= 1'b1; fixed_cnt_o <= dz_q; fail_o <= 1'b0;
            st_q   <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfix_chk.sv
module sfix_chk #(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [31:0]   stat_i,
  input logic          busy_i,
  input logic          done_o,
  input logic          fail_o,
  input logic [3:0]    fixed_cnt_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] mem_addr_o
);
  a_r1_zero_count_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i && stat_i[13:10] == 4'd0 |=> done_o && !fail_o && fixed_cnt_o == 4'd0);

  a_r3_rmw_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o && $past(mem_rd_o) |-> mem_addr_o == $past(mem_addr_o));

  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r4_fix_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> fixed_cnt_o <= 4'd8);

  a_r8_fail_no_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fail_o |-> fixed_cnt_o == 4'd0);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i && ($past(busy_i) || $past(start_i)));

  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(fail_o) && $stable(fixed_cnt_o));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_rd_o && !mem_wr_o);
endmodule

bind sector_fix_engine sfix_chk #(.AW(AW)) u_sfix_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stat_i     (stat_i),
  .busy_i     (busy),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .fixed_cnt_o(fixed_cnt_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/test_sector_fix_engine.sv
module test_sector_fix_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  w0 = '0, w1 = '0, w2 = '0, stat = '0;
  logic [103:0] ecc = '1;
  logic [8:0]   mem_addr;
  logic         mem_rd, mem_wr;
  logic [7:0]   mem_wdata;
  logic [7:0]   mem_rdata = '0;
  logic         done, fail;
  logic [3:0]   fixed;

  always #5 clk = ~clk;

  sector_fix_engine i_sector_fix_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .loc_w0_i(w0), .loc_w1_i(w1), .loc_w2_i(w2), .stat_i(stat), .ecc_i(ecc),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .fixed_cnt_o(fixed), .fail_o(fail)
  );

  // RAM model: one-cycle read latency
  logic [7:0] ram [512];
  logic [7:0] init_pat [512];
  logic [7:0] exp_mem [512];
  logic       ld_req = 1'b0;
  int         acc_n = 0;

  always @(posedge clk) begin
    if (ld_req) begin
      for (int i = 0; i < 512; i++) ram[i] <= init_pat[i];
      acc_n <= 0;
    end else begin
      if (mem_rd) mem_rdata <= ram[mem_addr];
      if (mem_wr) ram[mem_addr] <= mem_wdata;
      if (mem_rd || mem_wr) acc_n <= acc_n + 1;
    end
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  typedef struct packed {
    logic [3:0]   cnt;
    logic [103:0] vec;
    logic [7:0]   ecc_z;
    logic [7:0]   dat_z;
    logic [3:0]   exp_fix;
    logic         exp_fail;
  } case_t;

  localparam int NC = 12;
  localparam case_t CASES [NC] = '{
    // R1 count zero
    '{4'd0,  {8{13'd3}}, 8'd0, 8'd0, 4'd0, 1'b0},
    // R5 count 1: only index 0 used
    '{4'd1,  {13'd200, 13'd201, 13'd202, 13'd203, 13'd204, 13'd205, 13'd103, 13'd3}, 8'd0, 8'd0, 4'd1, 1'b0},
    // R4 last bit, first out-of-range position
    '{4'd3,  {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd4099, 13'd4092, 13'd103}, 8'd0, 8'd0, 4'd2, 1'b0},
    // R2 eight positions straddling word joins
    '{4'd8,  {13'd49, 13'd4003, 13'd3334, 13'd2778, 13'd2003, 13'd1233, 13'd803, 13'd9}, 8'd0, 8'd0, 4'd8, 1'b0},
    // R4 repeated position flips twice
    '{4'd2,  {13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd0, 13'd1000, 13'd1000}, 8'd0, 8'd0, 4'd2, 1'b0},
    // R7 clean erased page
    '{4'd9,  {8{13'd0}}, 8'd0, 8'd0, 4'd0, 1'b0},
    // R7 total exactly 8 split over ECC and data
    '{4'd15, {8{13'd0}}, 8'd3, 8'd5, 4'd5, 1'b0},
    // R8 nine data zeros
    '{4'd10, {8{13'd0}}, 8'd0, 8'd9, 4'd0, 1'b1},
    // R8 ECC alone over limit
    '{4'd12, {8{13'd0}}, 8'd9, 8'd0, 4'd0, 1'b1},
    // R6 eight ECC zeros, clean data
    '{4'd9,  {8{13'd0}}, 8'd8, 8'd0, 4'd0, 1'b0},
    // R7 eight data zeros
    '{4'd9,  {8{13'd0}}, 8'd0, 8'd8, 4'd8, 1'b0},
    // R4 all positions past the sector
    '{4'd5,  {13'd0, 13'd0, 13'd0, 13'd4097, 13'd6000, 13'd5000, 13'd8191, 13'd4099}, 8'd0, 8'd0, 4'd0, 1'b0}
  };

  int got_lat;
  logic got_fix_v;

  task automatic load_mem(input case_t c);
    for (int i = 0; i < 512; i++) init_pat[i] = (c.cnt > 4'd8) ? 8'hFF : 8'(i*37 + 5);
    if (c.cnt > 4'd8)
      for (int j = 0; j < int'(c.dat_z); j++)
        init_pat[(j*57 + 3) % 512][j % 8] = 1'b0;
    for (int i = 0; i < 512; i++) exp_mem[i] = init_pat[i];
    if (c.cnt != 4'd0 && c.cnt <= 4'd8) begin
      for (int k = 0; k < int'(c.cnt); k++) begin
        logic [12:0] p;
        p = c.vec[13*k +: 13] ^ 13'd3;
        if (p < 13'd4096) exp_mem[p >> 3][p[2:0]] = ~exp_mem[p >> 3][p[2:0]];
      end
    end else if (c.cnt > 4'd8 && int'(c.ecc_z) + int'(c.dat_z) <= 8) begin
      for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    end
    @(negedge clk); ld_req = 1'b1;
    @(negedge clk); ld_req = 1'b0;
  endtask

  task automatic launch(input case_t c);
    w0   = c.vec[31:0];
    w1   = c.vec[63:32];
    w2   = c.vec[95:64];
    stat = {8'hA5, c.vec[103:96], 2'b11, c.cnt, 10'h3FF};  // junk outside fields, R2
    ecc  = ~((104'd1 << c.ecc_z) - 104'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w0 = '0; w1 = '0; w2 = '0; stat = '0; ecc = '1;
  endtask

  task automatic wait_done(input string req);
    got_lat = 1;
    while (!done && got_lat < 5000) begin
      @(negedge clk);
      got_lat++;
    end
    got_fix_v = done;
    chk(done === 1'b1, req, int'(done), 1);
  endtask

  task automatic check_mem(input string req);
    int mism;
    int first;
    mism = 0; first = -1;
    for (int i = 0; i < 512; i++)
      if (ram[i] !== exp_mem[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    chk(mism == 0, req, (first < 0) ? 0 : int'(ram[first]), (first < 0) ? 0 : int'(exp_mem[first]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) init_pat[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done == 1'b0, "R11 done", int'(done), 0);
    chk(fail == 1'b0, "R11 fail", int'(fail), 0);
    chk(fixed == 4'd0, "R11 fixed", int'(fixed), 0);
    chk(!mem_rd && !mem_wr, "R11 strobes", int'({mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NC; n++) begin
      case_t c;
      c = CASES[n];
      load_mem(c);
      launch(c);
      wait_done($sformatf("R9 case%0d done", n));
      chk(fixed == c.exp_fix, $sformatf("R4/R7 case%0d fixed", n), int'(fixed), int'(c.exp_fix));
      chk(fail == c.exp_fail, $sformatf("R8 case%0d fail", n), int'(fail), int'(c.exp_fail));
      if (c.cnt == 4'd0) begin
        chk(got_lat == 1, "R1 latency", got_lat, 1);
        chk(acc_n == 0, "R1 no access", acc_n, 0);
      end
      if (n == 11) chk(acc_n == 0, "R4 skip no access", acc_n, 0);
      if (n == 5 || n == 9) chk(acc_n == 512, "R7 no fill when clean", acc_n, 512);
      @(negedge clk);
      chk(done == 1'b0, $sformatf("R9 case%0d pulse", n), int'(done), 0);
      chk(fixed == c.exp_fix && fail == c.exp_fail, $sformatf("R9 case%0d hold", n),
          int'({fail, fixed}), int'({c.exp_fail, c.exp_fix}));
      check_mem($sformatf("R3/R6 case%0d memory", n));
    end

    // R10: second start during a correction run is ignored
    begin
      case_t c;
      int dones;
      c = CASES[3];
      load_mem(c);
      launch(c);
      @(negedge clk);
      stat  = {16'h0, 2'b00, 4'd0, 10'h0};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      stat  = '0;
      dones = 0;
      for (int t = 0; t < 200; t++) begin
        if (done) begin
          dones++;
          chk(fixed == 4'd8, "R10 fixed", int'(fixed), 8);
        end
        @(negedge clk);
      end
      chk(dones == 1, "R10 single done", dones, 1);
      check_mem("R10 memory");
    end

    // R11 again: reset mid-scan clears outputs
    begin
      case_t c;
      c = CASES[10];
      load_mem(c);
      launch(c);
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!mem_rd && !mem_wr && !done && !fail && fixed == 4'd0, "R11 reset mid-run",
          int'({mem_rd, mem_wr, done, fail, fixed}), 0);
      rst_n = 1'b1;
      @(negedge clk);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule